// File: doc/BRIEF.md
# Byte-Addressed Serial EEPROM Target

This block is the digital core of a two-wire serial memory target. It oversamples the open-drain clock and data lines with the system clock and detects Start, repeated Start and Stop. It decodes the select byte and compares the three chip-enable bits in it with strap inputs. It accepts a two-byte memory address, most significant byte first, and stores the data bytes that follow in an on-chip register array. Its only bus-side output is a pull-down enable for the data line. A standby flag shows when the block is waiting for the next Start.

One address counter serves every operation and keeps its value from one transaction to the next. A write-mode address phase loads the counter and every stored or returned byte advances it. A read can therefore start without an address phase, from wherever the last operation stopped. A random read is a write-mode address phase followed by a repeated Start and a read-mode select byte. A sequential read goes on for as long as the master acknowledges each byte, and the counter wraps from the top address back to zero.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A falling data line while the clock is high (Start) takes the block out of standby, and a rising data line while the clock is high (Stop) puts it back into standby and releases the data line. Either condition abandons any byte in progress and leaves the counter as it was.
- R2: The select byte is the prefix 1010 in bits 7..4, the chip-enable bits in bits 3..1 and the read flag in bit 0 (1 = read). If the prefix or the chip-enable bits differ from `chip_sel_i`, the block does not acknowledge and stays in standby until the next Start.
- R3: After a write-mode select byte, the block acknowledges two address bytes, high byte first. The counter is loaded with the low ADDR_W bits of the 16-bit value and the upper bits are ignored. An address phase followed by a Stop only loads the counter.
- R4: Each data byte after the address phase is acknowledged and stored at the counter, and the counter then advances by one.
- R5: A repeated Start after the address phase, followed by a read-mode select byte, is acknowledged, and the first byte returned is the one at the newly loaded address.
- R6: A read-mode select byte after a plain Start returns the byte at the current counter value, and the counter then advances by one.
- R7: While the master acknowledges (data low on the 9th clock), reading continues from consecutive addresses. The address after 2^ADDR_W-1 is 0.
- R8: If the data line is high on the 9th clock of a read byte, the block stops driving and enters standby. The counter has still advanced past that byte.
- R9: The block turns its pull-down on only while the clock is low. It sends read data most significant bit first and samples incoming bits on the rising clock.
- R10: After reset the block is in standby with the data line released and every memory byte reads as 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| chip_sel_i | input | 3 | Strap value compared with select byte bits 3..1 |
| sda_pd_o | output | 1 | Data line pull-down enable (1 pulls low) |
| standby_o | output | 1 | High while idle and waiting for a Start |

## Verification
The assertions assume that each clock-low and clock-high phase lasts much longer than the synchronizer delay plus one cycle. They also assume that the master changes the data line only while the clock is low, except when it signals Start or Stop, and never issues Start or Stop while the block is pulling the line low. The bench holds the master's bus timing at eight system clocks per quarter bit and releases its own data drive during every acknowledge and read slot. It issues conditions only at byte boundaries, or in the middle of a byte it sends itself. Random writes, random reads and current-address reads with random lengths and addresses are mixed with directed cases for the top-address wrap, a refused select byte, an aborted address byte and a negative acknowledge.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] SEL_PREFIX = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_ACK,
    ST_RDAT,
    ST_RACK,
    ST_RLOAD
  } ee_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_d, sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_q = scl_ff[STAGES-1];
  assign sda_q = sda_ff[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_q;
      sda_d <= sda_q;
    end
  end

  assign sda_o      = sda_q;
  assign scl_rise_o = scl_q & ~scl_d;
  assign scl_fall_o = ~scl_q & scl_d;
  // conditions only count while the clock is stable high
  assign start_o    = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_o     = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/i2c_ee_addr_ctr.sv
module i2c_ee_addr_ctr #(
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= load_val_i;
    else if (inc_i)  addr_q <= addr_q + ADDR_W'(1);  // wraps at top
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem
  import i2c_ee_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[i] <= '0;
      else if (we_i && addr_i == ADDR_W'(i))   mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import i2c_ee_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] chip_sel_i,
  output logic       sda_pd_o,
  output logic       standby_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  ee_state_e         state_q, ret_q;
  logic [2:0]        bit_cnt_q;
  logic [BYTE_W-1:0] sh_q, ahi_q;
  logic              ack_on_q, sda_pd_q;

  logic [BYTE_W-1:0] byte_in, rdata;
  logic [ADDR_W-1:0] addr, load_val;
  logic              mem_we, ctr_load, ctr_inc, last_bit;

  assign byte_in  = {sh_q[BYTE_W-2:0], sda_s};
  assign last_bit = scl_rise && bit_cnt_q == 3'd7;
  assign load_val = ADDR_W'({ahi_q, byte_in});  // upper bits dropped

  always_comb begin
    mem_we   = 1'b0;
    ctr_load = 1'b0;
    ctr_inc  = 1'b0;
    if (!start_det && !stop_det && last_bit) begin
      case (state_q)
        ST_ALO:  ctr_load = 1'b1;
        ST_WDAT: begin mem_we = 1'b1; ctr_inc = 1'b1; end
        ST_RDAT: ctr_inc = 1'b1;  // counts even if master then NACKs
        default: ;
      endcase
    end
  end

  i2c_ee_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ctr_load),
    .load_val_i (load_val),
    .inc_i      (ctr_inc),
    .addr_o     (addr)
  );

  i2c_ee_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .addr_i  (addr),
    .wdata_i (byte_in),
    .rdata_o (rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ret_q     <= ST_IDLE;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      ahi_q     <= '0;
      ack_on_q  <= 1'b0;
      sda_pd_q  <= 1'b0;
    end else if (start_det) begin
      state_q   <= ST_DEV;
      bit_cnt_q <= '0;
      ack_on_q  <= 1'b0;
      sda_pd_q  <= 1'b0;
    end else if (stop_det) begin
      state_q  <= ST_IDLE;
      ack_on_q <= 1'b0;
      sda_pd_q <= 1'b0;
    end else begin
      case (state_q)
        ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
          if (scl_rise) begin
            sh_q      <= byte_in;
            bit_cnt_q <= bit_cnt_q + 3'd1;
            if (bit_cnt_q == 3'd7) begin
              ack_on_q <= 1'b0;
              state_q  <= ST_ACK;
              case (state_q)
                ST_DEV: begin
                  if (byte_in[7:4] == SEL_PREFIX && byte_in[3:1] == chip_sel_i)
                    ret_q <= byte_in[0] ? ST_RDAT : ST_AHI;
                  else
                    state_q <= ST_IDLE;
                end
                ST_AHI: begin
                  ahi_q <= byte_in;
                  ret_q <= ST_ALO;
                end
                default: ret_q <= ST_WDAT;
              endcase
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (!ack_on_q) begin
              sda_pd_q <= 1'b1;
              ack_on_q <= 1'b1;
            end else begin
              ack_on_q  <= 1'b0;
              bit_cnt_q <= '0;
              state_q   <= ret_q;
              if (ret_q == ST_RDAT) begin
                sh_q     <= rdata;
                sda_pd_q <= ~rdata[BYTE_W-1];
              end else begin
                sda_pd_q <= 1'b0;
              end
            end
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            sh_q      <= {sh_q[BYTE_W-2:0], 1'b0};
            bit_cnt_q <= bit_cnt_q + 3'd1;
            if (bit_cnt_q == 3'd7) state_q <= ST_RACK;
          end else if (scl_fall) begin
            sda_pd_q <= ~sh_q[BYTE_W-1];
          end
        end
        ST_RACK: begin
          if (scl_fall) sda_pd_q <= 1'b0;
          else if (scl_rise) state_q <= sda_s ? ST_IDLE : ST_RLOAD;
        end
        ST_RLOAD: begin
          if (scl_fall) begin
            sh_q      <= rdata;
            sda_pd_q  <= ~rdata[BYTE_W-1];
            bit_cnt_q <= '0;
            state_q   <= ST_RDAT;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pd_o  = sda_pd_q;
  assign standby_o = (state_q == ST_IDLE);
endmodule

// File: rtl/i2c_ee_chk.sv
module i2c_ee_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_pd_o,
  input logic standby_o,
  input logic start_det,
  input logic stop_det,
  input logic mem_we
);
  // R9
  pd_rise_clk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pd_o) |-> !scl_i);

  // R8
  standby_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |-> !sda_pd_o);

  // R1
  stop_to_standby_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> standby_o);

  // R1
  start_wakes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !standby_o);

  // R4
  write_on_clk_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> (scl_i && !standby_o));
endmodule

bind i2c_eeprom_target i2c_ee_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_i     (scl_i),
  .sda_pd_o  (sda_pd_o),
  .standby_o (standby_o),
  .start_det (start_det),
  .stop_det  (stop_det),
  .mem_we    (mem_we)
);

// File: tb/sim_i2c_eeprom_target.sv
module sim_i2c_eeprom_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q     = 8;
  localparam int AW    = 7;
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pd, standby;
  logic sda_bus;

  assign sda_bus = sda_m & ~sda_pd;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_eeprom_target #(.ADDR_W(AW)) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .chip_sel_i (STRAP),
    .sda_pd_o   (sda_pd),
    .standby_o  (standby)
  );

  int checks = 0;
  int errors = 0;
  int r9_viol = 0;
  bit done = 1'b0;
  logic [7:0] ref_mem [DEPTH];
  int ref_addr = 0;
  logic [7:0] wbuf [8];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw();
    scl_m = 1'b1; qw();
    sda_m = 1'b0; qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw();
    scl_m = 1'b1; qw();
    sda_m = 1'b1; qw();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; qw();
    scl_m = 1'b1; qw(); qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; qw();
    scl_m = 1'b1; qw();
    b = sda_bus; qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = (b == 1'b0);
  endtask

  task automatic recv_byte(input bit do_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(!do_ack);
  endtask

  function automatic logic [7:0] sel(input bit rd);
    return {4'b1010, STRAP, rd};
  endfunction

  task automatic addr_phase(input logic [15:0] a);
    bit ak;
    bus_start();
    send_byte(sel(1'b0), ak);
    check(ak, "R2 select ack", int'(ak), 1);
    send_byte(a[15:8], ak);
    check(ak, "R3 high addr ack", int'(ak), 1);
    send_byte(a[7:0], ak);
    check(ak, "R3 low addr ack", int'(ak), 1);
    ref_addr = int'(a[AW-1:0]);
  endtask

  task automatic do_write(input logic [15:0] a, input int n);
    bit ak;
    addr_phase(a);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ak);
      check(ak, "R4 data ack", int'(ak), 1);
      ref_mem[ref_addr] = wbuf[i];
      ref_addr = (ref_addr + 1) % DEPTH;
    end
    bus_stop();
  endtask

  task automatic read_body(input int n, input string req);
    logic [7:0] v;
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, v);
      check(v == ref_mem[ref_addr], req, int'(v), int'(ref_mem[ref_addr]));
      ref_addr = (ref_addr + 1) % DEPTH;
    end
    // R8: negative acknowledge on last byte
    check(standby == 1'b1 && sda_pd == 1'b0, "R8 standby after nack",
          int'({standby, sda_pd}), 2);
    bus_stop();
  endtask

  task automatic do_rand_read(input logic [15:0] a, input int n);
    bit ak;
    addr_phase(a);
    bus_start();
    send_byte(sel(1'b1), ak);
    check(ak, "R5 read select ack", int'(ak), 1);
    read_body(n, "R5 R7 random read data");
  endtask

  task automatic do_cur_read(input int n);
    bit ak;
    bus_start();
    send_byte(sel(1'b1), ak);
    check(ak, "R6 read select ack", int'(ak), 1);
    read_body(n, "R6 R7 current read data");
  endtask

  // R9: pull-down must not change while the bus clock is high
  logic pd_prev = 1'b0;
  logic scl_prev = 1'b1;
  always @(negedge clk) begin
    if (rst_n && scl_m && scl_prev && sda_pd != pd_prev) r9_viol++;
    pd_prev  <= sda_pd;
    scl_prev <= scl_m;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual %0d expected %0d", 190000, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ak;
    int unsigned seed;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 reset state
    check(standby == 1'b1, "R10 standby after reset", int'(standby), 1);
    check(sda_pd == 1'b0, "R10 released after reset", int'(sda_pd), 0);

    // R10 R6: memory clear, counter starts at 0
    do_cur_read(2);

    // R1 start leaves standby
    bus_start();
    check(standby == 1'b0, "R1 active after start", int'(standby), 0);
    // R2 wrong chip-enable bits
    send_byte({4'b1010, 3'b001, 1'b1}, ak);
    check(!ak, "R2 no ack on strap mismatch", int'(ak), 0);
    check(standby == 1'b1, "R2 standby after mismatch", int'(standby), 1);
    bus_stop();
    // R2 wrong prefix
    bus_start();
    send_byte({4'b1110, STRAP, 1'b0}, ak);
    check(!ak, "R2 no ack on prefix mismatch", int'(ak), 0);
    bus_stop();

    // R1 abort mid address byte, counter untouched
    bus_start();
    send_byte(sel(1'b0), ak);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_stop();
    check(standby == 1'b1, "R1 standby after stop", int'(standby), 1);
    do_cur_read(1);

    // R3 R4: upper address bits ignored, write wraps past top
    wbuf[0] = 8'h3C; wbuf[1] = 8'hC3; wbuf[2] = 8'h5A;
    do_write(16'hA5FE, 3);
    // R5 R7 R8: random read across the top address
    do_rand_read(16'h007F, 3);

    // R3 address-only write, then R6 current reads
    wbuf[0] = 8'h91; wbuf[1] = 8'h92;
    do_write(16'h0010, 2);
    addr_phase(16'h0010);
    bus_stop();
    do_cur_read(1);
    do_cur_read(1);

    // constrained random mix
    for (int it = 0; it < 20; it++) begin
      int unsigned op, n;
      logic [15:0] a;
      op = $urandom_range(2, 0);
      n  = $urandom_range(5, 1);
      a  = 16'($urandom);
      case (op)
        0: begin
          for (int k = 0; k < 8; k++) wbuf[k] = 8'($urandom);
          do_write(a, int'(n));
        end
        1: do_rand_read(a, int'(n));
        default: do_cur_read(int'(n));
      endcase
    end

    check(r9_viol == 0, "R9 drive changed while clock high", r9_viol, 0);

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule